// File: doc/BRIEF.md
# Converter Output Word Scrambler and Descrambler

This block sits between the parallel data word of a data converter and its output pins. When scrambling is switched on, the block hides the pattern of output bit toggles from the signal. Each data bit above bit 0 is replaced by its exclusive-OR with bit 0. Bit 0 itself leaves unchanged and acts as the key. The scrambled word, the overflow flag and an output-valid qualifier are registered together, so all three appear one clock after capture.

The same top module also holds the receiving-side descrambler. Because bit 0 travels in the clear, applying the same exclusive-OR to a received word restores the original. The descrambler is purely combinational and has its own enable input, so a receiver can be modelled next to the transmitter.

Top module: `xr_codec`

## Requirements
- R1: While `rst_n` is low, `dout`, `ovf_out` and `out_valid` are all 0.
- R2: If `rand_en` is 1 at a rising clock edge, then from the next edge `dout[i]` equals `din[i] ^ din[0]` for every i from 1 to 15, using the values captured at that edge.
- R3: If `rand_en` is 0 at a rising clock edge, then from the next edge `dout` equals the `din` captured at that edge, bit for bit.
- R4: `dout[0]` always equals the `din[0]` captured one edge earlier, whatever the value of `rand_en`.
- R5: `ovf_out` equals the `ovf_in` captured one edge earlier and does not depend on `rand_en`.
- R6: `out_valid` equals the `in_valid` captured one edge earlier and does not depend on `rand_en`.
- R7: The descrambler is combinational. With `dec_en` at 1, `dec_out[i]` is `dec_in[i] ^ dec_in[0]` for i from 1 to 15 and `dec_out[0]` is `dec_in[0]`. With `dec_en` at 0, `dec_out` equals `dec_in`.
- R8: Feeding `dout` into `dec_in`, with `dec_en` equal to the enable used at capture, gives back the captured `din` for both values of bit 0 and both enable settings.
- R9: `rand_en` applies only to the word captured at the same edge, so changing it every cycle gives each word its own setting and never mixes two settings.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| din | input | 16 | Converter data word |
| ovf_in | input | 1 | Overflow flag from the converter |
| in_valid | input | 1 | Qualifier for the word on `din` |
| rand_en | input | 1 | 1 scrambles the captured word, 0 passes it through plain |
| dout | output | 16 | Registered output word |
| ovf_out | output | 1 | Registered overflow flag |
| out_valid | output | 1 | Registered clock-out qualifier |
| dec_in | input | 16 | Received word for the descrambler |
| dec_en | input | 1 | 1 descrambles `dec_in`, 0 passes it through |
| dec_out | output | 16 | Restored word |

## Verification
The checker tests these properties on every clock:
- The one-clock transport of bit 0, the overflow flag and the valid qualifier.
- The plain path when the enable is low.
- With the enable high, that XOR-ing the upper output bits with output bit 0 gives back the captured input.

Only the bench scenarios show the following:
- That a round trip through the descrambler restores the original word.
- That the descrambler's own enable is obeyed.
- That a per-cycle toggle of the enable keeps each word whole.
- That reset clears the registered outputs while data is flowing.

// File: rtl/xr_pkg.sv
package xr_pkg;
  localparam int XR_DATA_W = 16;

  typedef enum logic {
    XR_PLAIN    = 1'b0,
    XR_SCRAMBLE = 1'b1
  } xr_mode_e;

  function automatic xr_mode_e xr_mode_of(input logic en);
    return en ? XR_SCRAMBLE : XR_PLAIN;
  endfunction
endpackage

// File: rtl/xr_xor_map.sv
// Keyed XOR map: bit 0 is the key and is copied through, upper bits are
// XORed with it when the mode selects scrambling. Self-inverse.
module xr_xor_map #(
  parameter int W = 16
) (
  input  logic [W-1:0]     word_in,
  input  xr_pkg::xr_mode_e mode,
  output logic [W-1:0]     word_out
);
  localparam int KEY_BIT = 0;

  logic key_active;
  assign key_active = (mode == xr_pkg::XR_SCRAMBLE) & word_in[KEY_BIT];

  assign word_out[KEY_BIT] = word_in[KEY_BIT];

  for (genvar g = KEY_BIT + 1; g < W; g++) begin : g_bit
    assign word_out[g] = word_in[g] ^ key_active;
  end
endmodule

// File: rtl/xr_out_stage.sv
// Output register: word, overflow and valid move together.
module xr_out_stage #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] word_d,
  input  logic         ovf_d,
  input  logic         vld_d,
  output logic [W-1:0] word_q,
  output logic         ovf_q,
  output logic         vld_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_q <= '0;
      ovf_q  <= 1'b0;
      vld_q  <= 1'b0;
    end else begin
      word_q <= word_d;
      ovf_q  <= ovf_d;
      vld_q  <= vld_d;
    end
  end
endmodule

// File: rtl/xr_codec.sv
module xr_codec #(
  parameter int W = xr_pkg::XR_DATA_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  input  logic         ovf_in,
  input  logic         in_valid,
  input  logic         rand_en,
  output logic [W-1:0] dout,
  output logic         ovf_out,
  output logic         out_valid,
  input  logic [W-1:0] dec_in,
  input  logic         dec_en,
  output logic [W-1:0] dec_out
);
  // Named internal events for the checker and for waveform reading.
  xr_pkg::xr_mode_e enc_mode;
  xr_pkg::xr_mode_e dec_mode;
  logic [W-1:0]     enc_word;

  assign enc_mode = xr_pkg::xr_mode_of(rand_en);
  assign dec_mode = xr_pkg::xr_mode_of(dec_en);

  xr_xor_map #(.W(W)) u_enc_map (
    .word_in  (din),
    .mode     (enc_mode),
    .word_out (enc_word)
  );

  xr_out_stage #(.W(W)) u_out (
    .clk    (clk),
    .rst_n  (rst_n),
    .word_d (enc_word),
    .ovf_d  (ovf_in),
    .vld_d  (in_valid),
    .word_q (dout),
    .ovf_q  (ovf_out),
    .vld_q  (out_valid)
  );

  xr_xor_map #(.W(W)) u_dec_map (
    .word_in  (dec_in),
    .mode     (dec_mode),
    .word_out (dec_out)
  );
endmodule

// File: rtl/xr_codec_chk.sv
module xr_codec_chk #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst_n,
  input logic [W-1:0] din,
  input logic         ovf_in,
  input logic         in_valid,
  input logic         rand_en,
  input logic [W-1:0] dout,
  input logic         ovf_out,
  input logic         out_valid
);
  // Upper output bits unscrambled with the output key bit.
  logic [W-2:0] upper_restored;
  assign upper_restored = dout[W-1:1] ^ {(W-1){dout[0]}};

  AST_KEY_BIT_DELAY: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> dout[0] == $past(din[0])); // R4

  AST_OVF_DELAY: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> ovf_out == $past(ovf_in)); // R5

  AST_VALID_DELAY: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> out_valid == $past(in_valid)); // R6

  AST_PLAIN_PATH: assert property (@(posedge clk) disable iff (!rst_n)
    !rand_en |=> dout == $past(din)); // R3

  AST_SCRAMBLE_PATH: assert property (@(posedge clk) disable iff (!rst_n)
    rand_en |=> upper_restored == $past(din[W-1:1])); // R2
endmodule

bind xr_codec xr_codec_chk #(.W(W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .din       (din),
  .ovf_in    (ovf_in),
  .in_valid  (in_valid),
  .rand_en   (rand_en),
  .dout      (dout),
  .ovf_out   (ovf_out),
  .out_valid (out_valid)
);

// File: tb/xr_codec_tb.sv
module xr_codec_tb;
  localparam int W  = 16;
  localparam int NV = 8;

  // Stimulus and expected results (scramble: upper bits inverted when bit 0 = 1).
  localparam logic [W-1:0] V_DIN [NV] = '{16'h1234, 16'h1235, 16'hFFFF, 16'h0001,
                                          16'hFFFF, 16'hA5A5, 16'hA5A5, 16'h0000};
  localparam logic         V_EN  [NV] = '{1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1};
  localparam logic         V_OVF [NV] = '{1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0};
  localparam logic [W-1:0] V_EXP [NV] = '{16'h1234, 16'hEDCB, 16'h0001, 16'hFFFF,
                                          16'hFFFF, 16'h5A5B, 16'hA5A5, 16'h0000};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [W-1:0] din = '0;
  logic ovf_in = 1'b0, in_valid = 1'b0, rand_en = 1'b0;
  logic [W-1:0] dout, dec_out;
  logic ovf_out, out_valid;
  logic [W-1:0] dec_in = '0;
  logic dec_en = 1'b0;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  xr_codec #(.W(W)) u_dut (
    .clk(clk), .rst_n(rst_n), .din(din), .ovf_in(ovf_in), .in_valid(in_valid),
    .rand_en(rand_en), .dout(dout), .ovf_out(ovf_out), .out_valid(out_valid),
    .dec_in(dec_in), .dec_en(dec_en), .dec_out(dec_out)
  );

  // Bench model: flip each upper bit individually when key and enable are set.
  function automatic logic [W-1:0] model(input logic [W-1:0] w, input logic en);
    logic [W-1:0] r;
    r = w;
    for (int i = 1; i < W; i++)
      if (en && w[0]) r[i] = ~w[i];
    return r;
  endfunction

  task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic drive_and_capture(input logic [W-1:0] d, input logic e,
                                   input logic o, input logic v);
    din = d; rand_en = e; ovf_in = o; in_valid = v;
    @(posedge clk); #1;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(8 * 100000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    // R1: reset state
    repeat (2) @(posedge clk);
    #1;
    check("R1 dout", dout, '0);
    check("R1 ovf_out", {15'd0, ovf_out}, '0);
    check("R1 out_valid", {15'd0, out_valid}, '0);
    @(negedge clk); rst_n = 1'b1;

    // Vector table walk: R2, R3, R4, R5, R6
    for (int k = 0; k < NV; k++) begin
      @(negedge clk);
      drive_and_capture(V_DIN[k], V_EN[k], V_OVF[k], k[0]);
      check(V_EN[k] ? "R2 table dout" : "R3 table dout", dout, V_EXP[k]);
      check("R4 key bit", {15'd0, dout[0]}, {15'd0, V_DIN[k][0]});
      check("R5 ovf", {15'd0, ovf_out}, {15'd0, V_OVF[k]});
      check("R6 valid", {15'd0, out_valid}, {15'd0, k[0]});
      check("R2/R3 model agrees", V_EXP[k], model(V_DIN[k], V_EN[k]));
    end

    // R7: descrambler alone, both enables
    dec_in = 16'h8001; dec_en = 1'b1; #1;
    check("R7 dec on", dec_out, 16'h7FFF);
    dec_en = 1'b0; #1;
    check("R7 dec off", dec_out, 16'h8001);
    dec_in = 16'h8000; dec_en = 1'b1; #1;
    check("R7 dec key 0", dec_out, 16'h8000);

    // R8: round trip for both key values and both enables
    for (int en = 0; en < 2; en++) begin
      for (int lsb = 0; lsb < 2; lsb++) begin
        for (int p = 0; p < 3; p++) begin
          logic [W-1:0] w;
          w = {16'h3C5A ^ (16'h1111 * p[15:0])} & 16'hFFFE | lsb[15:0];
          @(negedge clk);
          drive_and_capture(w, en[0], 1'b0, 1'b1);
          dec_in = dout; dec_en = en[0]; #1;
          check("R8 round trip", dec_out, w);
        end
      end
    end

    // R9: enable toggled every cycle, each word obeys its own setting
    for (int c = 0; c < 6; c++) begin
      logic [W-1:0] w;
      w = 16'h0F0F ^ {c[7:0], 8'h01};
      @(negedge clk);
      drive_and_capture(w, c[0], c[1], 1'b1);
      check("R9 per-word enable", dout, model(w, c[0]));
    end

    // R1: reset in the middle of traffic
    @(negedge clk);
    din = 16'hFFFF; rand_en = 1'b0; ovf_in = 1'b1; in_valid = 1'b1;
    @(posedge clk); #1;
    rst_n = 1'b0; #1;
    check("R1 mid reset dout", dout, '0);
    check("R1 mid reset flags", {14'd0, ovf_out, out_valid}, '0);
    @(posedge clk); #1;
    check("R1 held reset dout", dout, '0);
    @(negedge clk); rst_n = 1'b1;
    drive_and_capture(16'h0003, 1'b1, 1'b0, 1'b1);
    check("R2 after reset", dout, 16'hFFFD);

    finish_run();
  end
endmodule